// File: doc/BRIEF.md
# Indexed-Port Byte Memory with Lockable Regions

This block is a byte-wide storage array reached through a four-offset I/O window. The host first loads a 16-bit pointer by writing its low byte at offset 0 and its high byte at offset 1. It then moves data through offset 3, the data port. Offset 2 is unused.

A 16-entry slice of the map is reserved for a clock and control register block that lives outside this design. Data-port accesses that land there are not stored. They are turned into a one-cycle strobe toward that block, and on a read its returned byte is passed back to the host.

Two fixed 16-byte regions near the bottom of the map can each be locked, which makes them neither readable nor writable. Each lock bit is flipped by a sideband toggle request. The array size and the window base are parameters. A full-size map places the window at 0x1FF0 of an 8 KiB space; the defaults are kept small so the array stays modest.

Top module: `nvram_port_win`

## Requirements
- R1: A write at port offset 0 loads bits 7:0 of the 16-bit pointer from bits 7:0 of the write bus and keeps pointer bits 15:8. A write at offset 1 loads bits 15:8 and keeps bits 7:0. The pointer is 0 after reset.
- R2: A read at offset 3 (the data port) of a stored address returns the byte at the pointer on `io_rdata_o`. The data appears in the cycle after `io_rd_i`, with `io_rvalid_o` high for that one cycle.
- R3: A write at offset 3 to a stored address keeps only bits 7:0 of the 16-bit write bus.
- R4: A read at offset 0, 1 or 2 returns 0xFF. A write at offset 2 changes neither the pointer nor memory.
- R5: While lock bit 0 is set, data-port accesses to 0x20..0x2F are dropped. A read returns 0xFF and a write leaves the stored byte unchanged.
- R6: While lock bit 1 is set, data-port accesses to 0x30..0x3F are dropped in the same way.
- R7: A toggle request with index n inverts lock bit n only. Reset clears both lock bits.
- R8: Addresses WIN_BASE..WIN_BASE+15 (default 0x300..0x30F) are never stored. A data-port write there pulses `win_wr_o`, with the pointer's low 4 bits on `win_idx_o` and the write byte on `win_wdata_o`. A data-port read there pulses `win_rd_o` and returns the `win_rdata_i` value present in that cycle.
- R9: Addresses at or above MEM_BYTES (default 1024) that lie outside the window are not stored. A write there is dropped, without aliasing onto a lower address, and a read returns 0xFF.
- R10: A lock affects only its own region. Addresses next to it (0x1F, 0x40, and the other region while unlocked) stay accessible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_off_i | input | 2 | Port offset of the access |
| io_wr_i | input | 1 | Port write strobe |
| io_rd_i | input | 1 | Port read strobe |
| io_wdata_i | input | 16 | Write bus; only bits 7:0 are used |
| io_rdata_o | output | 8 | Read data, valid with io_rvalid_o |
| io_rvalid_o | output | 1 | Read data valid, one cycle after io_rd_i |
| lock_tgl_i | input | 1 | Lock toggle request |
| lock_idx_i | input | 1 | Index of the lock bit to invert |
| win_wr_o | output | 1 | Write strobe to the register window |
| win_rd_o | output | 1 | Read strobe to the register window |
| win_idx_o | output | 4 | Register index inside the window |
| win_wdata_o | output | 8 | Write byte toward the register window |
| win_rdata_i | input | 8 | Byte returned by the register window |

## Verification
The hardest situation to reach is a dropped write inside a locked region. Its only visible effect is that an older byte survives, so the stimulus first stores a known pattern at both ends of each region while unlocked. It then locks the region, writes a different value, reads it back (expecting 0xFF), unlocks, and reads again to confirm the original byte. Non-aliasing above the array size is shown the same way: a byte is stored at address 0 before a write to the address that would wrap onto it.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

    localparam int PTR_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int OFF_W     = 2;
    localparam int NUM_LOCKS = 2;
    localparam int LOCK_SPAN = 16;
    localparam int LOCK_ORG  = 32'h20;
    localparam int WIN_SPAN  = 16;
    localparam int WIN_IDX_W = $clog2(WIN_SPAN);
    localparam int LIDX_W    = $clog2(NUM_LOCKS);

    typedef enum logic [OFF_W-1:0] {
        OFF_PTR_LO = 2'd0,
        OFF_PTR_HI = 2'd1,
        OFF_SPARE  = 2'd2,
        OFF_DATA   = 2'd3
    } port_off_e;

    typedef enum logic [1:0] {
        CLS_STORE = 2'd0,
        CLS_WIN   = 2'd1,
        CLS_VOID  = 2'd2,
        CLS_PORT  = 2'd3
    } acc_cls_e;

    typedef struct packed {
        logic     valid;
        acc_cls_e cls;
    } rd_tag_t;

    function automatic logic [PTR_W:0] lock_lo(input int idx);
        return (PTR_W+1)'(LOCK_ORG + idx * LOCK_SPAN);
    endfunction

    function automatic logic [PTR_W:0] lock_hi(input int idx);
        return (PTR_W+1)'(LOCK_ORG + idx * LOCK_SPAN + LOCK_SPAN - 1);
    endfunction

    function automatic logic in_span(input logic [PTR_W-1:0] a,
                                     input logic [PTR_W:0] lo,
                                     input logic [PTR_W:0] hi);
        return ({1'b0, a} >= lo) && ({1'b0, a} <= hi);
    endfunction

endpackage

// File: rtl/nvw_addr_reg.sv
module nvw_addr_reg
    import nvw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_i,
    input  port_off_e            off_i,
    input  logic [BYTE_W-1:0]    byte_i,
    output logic [PTR_W-1:0]     ptr_o
);
    logic [PTR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (wr_i) begin
            case (off_i)
                OFF_PTR_LO: ptr_q[BYTE_W-1:0]     <= byte_i;
                OFF_PTR_HI: ptr_q[PTR_W-1:BYTE_W] <= byte_i;
                default:    ptr_q                 <= ptr_q;
            endcase
        end
    end

    assign ptr_o = ptr_q;

    // R1: a low-byte load leaves the high byte alone
    p_lo_keeps_hi_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_i && off_i == OFF_PTR_LO) |=> ptr_q[PTR_W-1:BYTE_W] == $past(ptr_q[PTR_W-1:BYTE_W]));

    // R1: a high-byte load leaves the low byte alone
    p_hi_keeps_lo_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_i && off_i == OFF_PTR_HI) |=> ptr_q[BYTE_W-1:0] == $past(ptr_q[BYTE_W-1:0]));

    // R4: offsets other than the two pointer bytes never move the pointer
    p_spare_inert_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_i && (off_i == OFF_SPARE || off_i == OFF_DATA)) |=> $stable(ptr_q));
endmodule

// File: rtl/nvw_lock_ctl.sv
module nvw_lock_ctl
    import nvw_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tgl_i,
    input  logic [LIDX_W-1:0]      idx_i,
    input  logic [PTR_W-1:0]       ptr_i,
    output logic [NUM_LOCKS-1:0]   lock_o,
    output logic [NUM_LOCKS-1:0]   hit_o,
    output logic                   blocked_o
);
    logic [NUM_LOCKS-1:0] lock_q;
    logic [NUM_LOCKS-1:0] hit;

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_region
        assign hit[g] = in_span(ptr_i, lock_lo(g), lock_hi(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= '0;
        end else if (tgl_i) begin
            lock_q[idx_i] <= ~lock_q[idx_i];
        end
    end

    assign lock_o    = lock_q;
    assign hit_o     = hit;
    assign blocked_o = |(hit & lock_q);

    // R7: reset clears every lock bit
    p_lock_clear_r7: assert property (@(posedge clk)
        rst |=> lock_q == '0);

    // R7: a toggle flips exactly one bit
    p_lock_flip_r7: assert property (@(posedge clk) disable iff (rst)
        tgl_i |=> $countones(lock_q ^ $past(lock_q)) == 1);

    // R7: without a toggle the lock state holds
    p_lock_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !tgl_i |=> $stable(lock_q));
endmodule

// File: rtl/nvw_decode.sv
module nvw_decode
    import nvw_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    parameter int WIN_BASE  = 32'h300
) (
    input  logic [PTR_W-1:0] ptr_i,
    input  logic             blocked_i,
    output acc_cls_e         cls_o
);
    localparam logic [PTR_W:0] WIN_LO  = (PTR_W+1)'(WIN_BASE);
    localparam logic [PTR_W:0] WIN_HI  = (PTR_W+1)'(WIN_BASE + WIN_SPAN - 1);
    localparam logic [PTR_W:0] MEM_TOP = (PTR_W+1)'(MEM_BYTES);

    always_comb begin
        if (blocked_i) begin
            cls_o = CLS_VOID;
        end else if (in_span(ptr_i, WIN_LO, WIN_HI)) begin
            cls_o = CLS_WIN;
        end else if ({1'b0, ptr_i} < MEM_TOP) begin
            cls_o = CLS_STORE;
        end else begin
            cls_o = CLS_VOID;
        end
    end
endmodule

// File: rtl/nvw_store.sv
module nvw_store
    import nvw_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic                         clk,
    input  logic                         we_i,
    input  logic                         re_i,
    input  logic [$clog2(DEPTH)-1:0]     addr_i,
    input  logic [BYTE_W-1:0]            wdata_i,
    output logic [BYTE_W-1:0]            rdata_o
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
        if (re_i) begin
            rd_q <= mem[addr_i];
        end
    end

    assign rdata_o = rd_q;
endmodule

// File: rtl/nvram_port_win.sv
module nvram_port_win
    import nvw_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    parameter int WIN_BASE  = 32'h300,
    parameter int WBUS_W    = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         io_off_i,
    input  logic               io_wr_i,
    input  logic               io_rd_i,
    input  logic [WBUS_W-1:0]  io_wdata_i,
    output logic [7:0]         io_rdata_o,
    output logic               io_rvalid_o,
    input  logic               lock_tgl_i,
    input  logic               lock_idx_i,
    output logic               win_wr_o,
    output logic               win_rd_o,
    output logic [3:0]         win_idx_o,
    output logic [7:0]         win_wdata_o,
    input  logic [7:0]         win_rdata_i
);
    localparam int MEM_AW = $clog2(MEM_BYTES);
    localparam logic [PTR_W:0] WIN_LO  = (PTR_W+1)'(WIN_BASE);
    localparam logic [PTR_W:0] WIN_HI  = (PTR_W+1)'(WIN_BASE + WIN_SPAN - 1);

    port_off_e            off;
    logic [PTR_W-1:0]     ptr;
    logic [NUM_LOCKS-1:0] lock_bits;
    logic [NUM_LOCKS-1:0] lock_hit;
    logic                 blocked;
    acc_cls_e             cls;
    logic                 data_acc;
    logic                 mem_we;
    logic                 mem_re;
    logic [BYTE_W-1:0]    mem_q;
    logic [BYTE_W-1:0]    byte_in;
    rd_tag_t              tag_q;
    logic [BYTE_W-1:0]    win_q;

    assign off     = port_off_e'(io_off_i);
    assign byte_in = io_wdata_i[BYTE_W-1:0];

    nvw_addr_reg u_ptr (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (io_wr_i),
        .off_i  (off),
        .byte_i (byte_in),
        .ptr_o  (ptr)
    );

    nvw_lock_ctl u_lock (
        .clk       (clk),
        .rst       (rst),
        .tgl_i     (lock_tgl_i),
        .idx_i     (lock_idx_i),
        .ptr_i     (ptr),
        .lock_o    (lock_bits),
        .hit_o     (lock_hit),
        .blocked_o (blocked)
    );

    nvw_decode #(
        .MEM_BYTES (MEM_BYTES),
        .WIN_BASE  (WIN_BASE)
    ) u_dec (
        .ptr_i     (ptr),
        .blocked_i (blocked),
        .cls_o     (cls)
    );

    assign data_acc = (off == OFF_DATA);
    assign mem_we   = io_wr_i && data_acc && (cls == CLS_STORE);
    assign mem_re   = io_rd_i && data_acc && (cls == CLS_STORE);

    nvw_store #(
        .DEPTH (MEM_BYTES)
    ) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .re_i    (mem_re),
        .addr_i  (ptr[MEM_AW-1:0]),
        .wdata_i (byte_in),
        .rdata_o (mem_q)
    );

    assign win_wr_o    = io_wr_i && data_acc && (cls == CLS_WIN);
    assign win_rd_o    = io_rd_i && data_acc && (cls == CLS_WIN);
    assign win_idx_o   = ptr[WIN_IDX_W-1:0];
    assign win_wdata_o = byte_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '{valid: 1'b0, cls: CLS_PORT};
            win_q <= '1;
        end else begin
            tag_q.valid <= io_rd_i;
            if (io_rd_i) begin
                tag_q.cls <= data_acc ? cls : CLS_PORT;
            end
            if (win_rd_o) begin
                win_q <= win_rdata_i;
            end
        end
    end

    always_comb begin
        case (tag_q.cls)
            CLS_STORE: io_rdata_o = mem_q;
            CLS_WIN:   io_rdata_o = win_q;
            default:   io_rdata_o = '1;
        endcase
    end

    assign io_rvalid_o = tag_q.valid;

    // R2: read data is only flagged one cycle after a read strobe
    p_rvalid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        io_rvalid_o |-> $past(io_rd_i));

    // R5/R6: the array is never written inside a locked region
    p_lock_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (lock_hit & lock_bits) == '0);

    // R8: the register window never reaches the array
    p_win_nostore_r8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !in_span(ptr, WIN_LO, WIN_HI));

    // R9: no array write from a pointer past the configured size
    p_range_r9: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ({1'b0, ptr} < (PTR_W+1)'(MEM_BYTES)));

    // R8: at most one destination per access
    p_one_dest_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, win_wr_o}));
endmodule

// File: tb/test_nvram_port_win.sv
module test_nvram_port_win;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  io_off_i = '0;
    logic        io_wr_i = 1'b0;
    logic        io_rd_i = 1'b0;
    logic [15:0] io_wdata_i = '0;
    logic [7:0]  io_rdata_o;
    logic        io_rvalid_o;
    logic        lock_tgl_i = 1'b0;
    logic        lock_idx_i = 1'b0;
    logic        win_wr_o;
    logic        win_rd_o;
    logic [3:0]  win_idx_o;
    logic [7:0]  win_wdata_o;
    logic [7:0]  win_rdata_i = '0;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    nvram_port_win i_nvram_port_win (
        .clk         (clk),
        .rst         (rst),
        .io_off_i    (io_off_i),
        .io_wr_i     (io_wr_i),
        .io_rd_i     (io_rd_i),
        .io_wdata_i  (io_wdata_i),
        .io_rdata_o  (io_rdata_o),
        .io_rvalid_o (io_rvalid_o),
        .lock_tgl_i  (lock_tgl_i),
        .lock_idx_i  (lock_idx_i),
        .win_wr_o    (win_wr_o),
        .win_rd_o    (win_rd_o),
        .win_idx_o   (win_idx_o),
        .win_wdata_o (win_wdata_o),
        .win_rdata_i (win_rdata_i)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic port_wr(input logic [1:0] off, input logic [15:0] d);
        @(negedge clk);
        io_off_i = off; io_wdata_i = d; io_wr_i = 1'b1;
        @(negedge clk);
        io_wr_i = 1'b0;
    endtask

    task automatic port_rd(input logic [1:0] off, input logic [7:0] exp, input string req);
        @(negedge clk);
        io_off_i = off; io_rd_i = 1'b1;
        @(negedge clk);
        io_rd_i = 1'b0;
        chk({req, " rvalid"}, {15'd0, io_rvalid_o}, 16'd1);
        chk(req, {8'd0, io_rdata_o}, {8'd0, exp});
    endtask

    task automatic set_ptr(input logic [15:0] a);
        port_wr(2'd0, {8'h00, a[7:0]});
        port_wr(2'd1, {8'h00, a[15:8]});
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        set_ptr(a);
        port_wr(2'd3, {8'h00, d});
    endtask

    task automatic peek(input logic [15:0] a, input logic [7:0] exp, input string req);
        set_ptr(a);
        port_rd(2'd3, exp, req);
    endtask

    task automatic toggle(input logic idx);
        @(negedge clk);
        lock_tgl_i = 1'b1; lock_idx_i = idx;
        @(negedge clk);
        lock_tgl_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R2 rvalid idle after reset", {15'd0, io_rvalid_o}, 16'd0);
        chk("R8 no window strobe after reset", {14'd0, win_wr_o, win_rd_o}, 16'd0);
        // R1: pointer is zero after reset
        port_wr(2'd3, 16'h0077);
        peek(16'h0000, 8'h77, "R1 pointer reset to zero");
    endtask

    task automatic t_pointer_bytes();
        poke(16'h0012, 8'hA1);
        poke(16'h0112, 8'hB2);
        port_wr(2'd0, 16'hAB05);          // pointer becomes 0x0105
        port_wr(2'd3, 16'h00C3);
        port_wr(2'd1, 16'h0000);          // pointer becomes 0x0005
        port_wr(2'd3, 16'h00D4);
        peek(16'h0105, 8'hC3, "R1 low byte load keeps high byte");
        peek(16'h0005, 8'hD4, "R1 high byte load keeps low byte");
        peek(16'h0012, 8'hA1, "R2 read stored byte");
        peek(16'h0112, 8'hB2, "R2 read stored byte high page");
    endtask

    task automatic t_write_width();
        poke(16'h0040, 8'h00);
        port_wr(2'd3, 16'h3C77);
        peek(16'h0040, 8'h77, "R3 only low byte stored");
    endtask

    task automatic t_other_ports();
        poke(16'h0050, 8'h5D);
        port_rd(2'd0, 8'hFF, "R4 read offset 0");
        port_rd(2'd1, 8'hFF, "R4 read offset 1");
        port_rd(2'd2, 8'hFF, "R4 read offset 2");
        port_wr(2'd2, 16'h0099);
        port_rd(2'd3, 8'h5D, "R4 offset 2 write inert");
    endtask

    task automatic t_lock0();
        poke(16'h001F, 8'h60);
        poke(16'h0020, 8'h61);
        poke(16'h002F, 8'h62);
        poke(16'h0030, 8'h63);
        poke(16'h003F, 8'h64);
        toggle(1'b0);
        peek(16'h0020, 8'hFF, "R5 locked read low end");
        peek(16'h002F, 8'hFF, "R5 locked read high end");
        poke(16'h002F, 8'h00);
        peek(16'h001F, 8'h60, "R10 below region 0 open");
        peek(16'h0030, 8'h63, "R10 region 1 open while unlocked");
        toggle(1'b0);
        peek(16'h002F, 8'h62, "R5 locked write dropped");
    endtask

    task automatic t_lock1();
        toggle(1'b1);
        peek(16'h0030, 8'hFF, "R6 locked read low end");
        peek(16'h003F, 8'hFF, "R6 locked read high end");
        poke(16'h003F, 8'h11);
        peek(16'h0040, 8'h77, "R10 above region 1 open");
        peek(16'h0020, 8'h61, "R10 region 0 open while unlocked");
        toggle(1'b1);
        peek(16'h003F, 8'h64, "R6 locked write dropped");
    endtask

    task automatic t_toggle_reset();
        toggle(1'b0);
        toggle(1'b1);
        toggle(1'b1);                     // bit 1 back off, bit 0 stays set
        peek(16'h0020, 8'hFF, "R7 other bit unaffected by toggle");
        peek(16'h0030, 8'h63, "R7 toggled bit cleared again");
        do_reset();
        peek(16'h0020, 8'h61, "R7 reset clears lock");
    endtask

    task automatic t_window();
        poke(16'h02FF, 8'h81);
        poke(16'h0310, 8'h82);
        set_ptr(16'h0305);
        @(negedge clk);
        io_off_i = 2'd3; io_wdata_i = 16'hEE4B; io_wr_i = 1'b1;
        #1;
        chk("R8 window write strobe", {15'd0, win_wr_o}, 16'd1);
        chk("R8 window index", {12'd0, win_idx_o}, 16'd5);
        chk("R8 window write byte", {8'd0, win_wdata_o}, 16'h004B);
        @(negedge clk);
        io_wr_i = 1'b0;
        win_rdata_i = 8'h5E;
        io_rd_i = 1'b1;
        #1;
        chk("R8 window read strobe", {15'd0, win_rd_o}, 16'd1);
        @(negedge clk);
        io_rd_i = 1'b0;
        win_rdata_i = 8'h00;
        chk("R8 window read data", {8'd0, io_rdata_o}, 16'h005E);
        peek(16'h02FF, 8'h81, "R8 below window stored");
        peek(16'h0310, 8'h82, "R8 above window stored");
    endtask

    task automatic t_range();
        poke(16'h0000, 8'h11);
        poke(16'h0400, 8'h55);
        peek(16'h0400, 8'hFF, "R9 read past size");
        peek(16'hFFFF, 8'hFF, "R9 read top of map");
        peek(16'h0000, 8'h11, "R9 write past size no alias");
    endtask

    initial begin
        #(200000 * 10);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_pointer_bytes();
        t_write_width();
        t_other_ports();
        t_lock0();
        t_lock1();
        t_toggle_reset();
        t_window();
        t_range();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule